// File: doc/BRIEF.md
# Prioritized Banked Interrupt Controller

This block collects level-sensitive interrupt requests from up to 96 peripheral sources and presents them to a processor on two lines: a normal interrupt request and a fast interrupt request. Sources are grouped in banks of 32. Source n lives in bank n/32 at bit n mod 32. Each bank has an enable mask and a steering word that sends each source to one of the two outputs. Each bank also has three read-only status words: the raw input state, the enabled sources routed to the normal line, and the enabled sources routed to the fast line.

A table of priority slots, one slot per source, names which source each slot stands for. The lowest-numbered slot that is valid and whose source has a normal request pending wins. A single read of the winner register returns that source number with a valid flag, so software never scans bit vectors. A wake output tells the power logic that the processor should leave idle. A control bit picks whether any raw input wakes it or only enabled ones do. Software reaches every register through a plain 32-bit read/write port with byte addresses.

Top module: `banked_intc`

## Requirements
- R1: After reset every mask and steering bit is 0, the control bit is 0, priority slot i holds source i with its valid flag set, and irq_o, fiq_o and the winner register are 0 while no input is high.
- R2: Bank b registers sit at base 0x000, 0x09C or 0x130 for b = 0, 1, 2. The offsets are +0x00 normal pending, +0x04 mask, +0x08 steering, +0x0C fast pending and +0x10 raw. The control register is at 0x014 and the winner register is at 0x018.
- R3: A mask bit of 1 enables its source. The normal pending word reads raw AND mask AND NOT steering, and a masked source drives neither output.
- R4: A steering bit of 1 moves an enabled source to the fast pending word and to fiq_o, and takes it off irq_o. A steering bit of 0 keeps it on the normal side.
- R5: irq_o is the OR of all normal pending bits and fiq_o is the OR of all fast pending bits. Both follow an input change one clock later, because the inputs pass through one register stage.
- R6: The raw word shows the registered input levels whatever the mask and steering say.
- R7: Priority slot i sits at 0x01C+4i for i<32, at 0x0B0+4(i-32) for i<64 and at 0x144+4(i-64) above that. Bit 31 is the valid flag and bits 6:0 are the source number. Writes to these two fields read back exactly, and the other bits read 0.
- R8: When a normal request is pending in a winning slot, the winner register reads bit 31 = 1 with that source number in bits 30:16 and zeros elsewhere. The winning slot is the lowest-numbered slot that is valid and names a source with a normal request pending. Sources steered to the fast line never win.
- R9: A slot whose valid flag is 0, or whose source number is 96 or more, takes no part in the selection.
- R10: With control bit 0 set to 1, wake_o is high only when some enabled source is high. With it at 0, wake_o is high when any raw input is high.
- R11: Writes to the pending, raw and winner registers change nothing. Read data appears on bus_rdata in the cycle after bus_rd and holds until the next read.
- R12: Inputs are not latched. When an input falls, its pending bits and outputs clear one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_lvl | input | 96 | Level interrupt inputs, one per source |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Leave-idle request |

## Verification
The bench reprograms slot 0 to name a higher-numbered source. A resolver that ranked by source number instead of slot order would keep reporting the lower source. It then clears that slot's valid flag and points it at source 100. A design that ignored the flag or indexed past the last source would report a wrong winner or garbage. Steering a pending source to the fast line must drop it from the winner register and from irq_o, which exposes a resolver that reads raw AND mask. Both wake modes are tried with a source that is high but masked, and a wrongly polarised control bit shows up at once. Writes to every read-only word must leave the status unchanged. Priority slots in the third address window are read back to catch an address map that is off by one step.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int BANK_W       = 32;
    localparam int MAX_BANKS    = 3;
    localparam int OFS_IRQ_PEND = 'h00;
    localparam int OFS_MASK     = 'h04;
    localparam int OFS_STEER    = 'h08;
    localparam int OFS_FIQ_PEND = 'h0C;
    localparam int OFS_RAW      = 'h10;
    localparam int CTRL_ADDR    = 'h14;
    localparam int WIN_ADDR     = 'h18;

    // Base byte offset of a bank's register group; the windows interleave
    // with the priority slot windows, so they are irregular.
    function automatic int bank_base(input int b);
        case (b)
            0:       return 'h000;
            1:       return 'h09C;
            default: return 'h130;
        endcase
    endfunction

    // Byte address of priority slot i.
    function automatic int slot_addr(input int i);
        if (i < 32)      return 'h01C + 4 * i;
        else if (i < 64) return 'h0B0 + 4 * (i - 32);
        else             return 'h144 + 4 * (i - 64);
    endfunction

    function automatic logic [31:0] win_pack(input logic vld, input logic [14:0] src);
        return {vld, src, 16'h0000};
    endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = 96,
    parameter int ADDR_W    = 9,
    parameter int NUM_BANKS = 3,
    parameter int SRC_W     = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic                          rd,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [31:0]                   wdata,
    input  logic [NUM_BANKS*BANK_W-1:0]   raw_w,
    input  logic [NUM_BANKS*BANK_W-1:0]   irqp_w,
    input  logic [NUM_BANKS*BANK_W-1:0]   fiqp_w,
    input  logic [31:0]                   win_word,
    output logic [NUM_BANKS*BANK_W-1:0]   mask_o,
    output logic [NUM_BANKS*BANK_W-1:0]   steer_o,
    output logic                          wake_sel_o,
    output logic [NUM_SRC-1:0]            pvld_o,
    output logic [NUM_SRC*SRC_W-1:0]      psrc_o,
    output logic [31:0]                   rdata_o
);
    typedef struct packed {
        logic [NUM_BANKS-1:0][BANK_W-1:0] mask;
        logic [NUM_BANKS-1:0][BANK_W-1:0] steer;
        logic                             wake_sel;
        logic [NUM_SRC-1:0]               pvld;
        logic [NUM_SRC-1:0][SRC_W-1:0]    psrc;
        logic [31:0]                      rdata;
    } regs_t;

    function automatic regs_t reset_state();
        regs_t r;
        r = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            r.pvld[i] = 1'b1;
            r.psrc[i] = SRC_W'(i);
        end
        return r;
    endfunction

    regs_t regs_d, regs_q;
    logic [31:0] rd_val;

    always_comb begin
        regs_d = regs_q;
        rd_val = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == ADDR_W'(bank_base(b) + OFS_IRQ_PEND))
                rd_val = irqp_w[b*BANK_W +: BANK_W];
            if (addr == ADDR_W'(bank_base(b) + OFS_FIQ_PEND))
                rd_val = fiqp_w[b*BANK_W +: BANK_W];
            if (addr == ADDR_W'(bank_base(b) + OFS_RAW))
                rd_val = raw_w[b*BANK_W +: BANK_W];
            if (addr == ADDR_W'(bank_base(b) + OFS_MASK)) begin
                rd_val = regs_q.mask[b];
                if (wr) regs_d.mask[b] = wdata;
            end
            if (addr == ADDR_W'(bank_base(b) + OFS_STEER)) begin
                rd_val = regs_q.steer[b];
                if (wr) regs_d.steer[b] = wdata;
            end
        end
        if (addr == ADDR_W'(CTRL_ADDR)) begin
            rd_val = {31'b0, regs_q.wake_sel};
            if (wr) regs_d.wake_sel = wdata[0];
        end
        if (addr == ADDR_W'(WIN_ADDR))
            rd_val = win_word;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (addr == ADDR_W'(slot_addr(i))) begin
                rd_val = {regs_q.pvld[i], {(31-SRC_W){1'b0}}, regs_q.psrc[i]};
                if (wr) begin
                    regs_d.pvld[i] = wdata[31];
                    regs_d.psrc[i] = wdata[SRC_W-1:0];
                end
            end
        end
        if (rd) regs_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= reset_state();
        else        regs_q <= regs_d;
    end

    assign mask_o     = regs_q.mask;
    assign steer_o    = regs_q.steer;
    assign wake_sel_o = regs_q.wake_sel;
    assign pvld_o     = regs_q.pvld;
    assign psrc_o     = regs_q.psrc;
    assign rdata_o    = regs_q.rdata;
endmodule

// File: rtl/intc_pend.sv
module intc_pend
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = 96,
    parameter int NUM_BANKS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          src_i,
    input  logic [NUM_BANKS*BANK_W-1:0] mask_i,
    input  logic [NUM_BANKS*BANK_W-1:0] steer_i,
    input  logic                        wake_sel_i,
    output logic [NUM_BANKS*BANK_W-1:0] raw_w,
    output logic [NUM_BANKS*BANK_W-1:0] irqp_w,
    output logic [NUM_BANKS*BANK_W-1:0] fiqp_w,
    output logic                        irq_o,
    output logic                        fiq_o,
    output logic                        wake_o
);
    localparam int TOT_W = NUM_BANKS * BANK_W;

    typedef struct packed {
        logic [NUM_SRC-1:0] lvl;
    } pend_t;

    pend_t pend_d, pend_q;
    logic [NUM_BANKS-1:0] bank_irq, bank_fiq, bank_any, bank_en;

    always_comb begin
        pend_d     = pend_q;
        pend_d.lvl = src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign raw_w = TOT_W'(pend_q.lvl);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] raw_b, en_b;
        assign raw_b = raw_w[b*BANK_W +: BANK_W];
        assign en_b  = raw_b & mask_i[b*BANK_W +: BANK_W];
        assign irqp_w[b*BANK_W +: BANK_W] = en_b & ~steer_i[b*BANK_W +: BANK_W];
        assign fiqp_w[b*BANK_W +: BANK_W] = en_b &  steer_i[b*BANK_W +: BANK_W];
        assign bank_irq[b] = |irqp_w[b*BANK_W +: BANK_W];
        assign bank_fiq[b] = |fiqp_w[b*BANK_W +: BANK_W];
        assign bank_any[b] = |raw_b;
        assign bank_en[b]  = |en_b;
    end

    assign irq_o  = |bank_irq;
    assign fiq_o  = |bank_fiq;
    assign wake_o = wake_sel_i ? (|bank_en) : (|bank_any);
endmodule

// File: rtl/intc_prio.sv
module intc_prio
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = 96,
    parameter int NUM_BANKS = 3,
    parameter int SRC_W     = 7
) (
    input  logic [NUM_BANKS*BANK_W-1:0] irqp_w,
    input  logic [NUM_SRC-1:0]          pvld_i,
    input  logic [NUM_SRC*SRC_W-1:0]    psrc_i,
    output logic [31:0]                 win_word
);
    localparam int EXT_W = 2 ** SRC_W;
    localparam logic [SRC_W:0] SRC_LIM = (SRC_W+1)'(NUM_SRC);

    logic [EXT_W-1:0] pend_ext;
    logic             found;
    logic [SRC_W-1:0] winner;

    assign pend_ext = EXT_W'(irqp_w);

    // Scanned from the top slot down so the lowest matching slot is the last
    // assignment and wins.
    always_comb begin
        found  = 1'b0;
        winner = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            logic [SRC_W-1:0] s;
            s = psrc_i[i*SRC_W +: SRC_W];
            if (pvld_i[i] && ({1'b0, s} < SRC_LIM) && pend_ext[s]) begin
                found  = 1'b1;
                winner = s;
            end
        end
    end

    assign win_word = found ? win_pack(1'b1, 15'(winner)) : 32'h0;
endmodule

// File: rtl/banked_intc.sv
module banked_intc
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 96,
    parameter int ADDR_W  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_lvl,
    output logic               irq_o,
    output logic               fiq_o,
    output logic               wake_o
);
    localparam int NUM_BANKS = (NUM_SRC + BANK_W - 1) / BANK_W;
    localparam int TOT_W     = NUM_BANKS * BANK_W;
    localparam int SRC_W     = $clog2(TOT_W);

    logic [TOT_W-1:0]         raw_w, irqp_w, fiqp_w, mask_w, steer_w;
    logic                     wake_sel;
    logic [NUM_SRC-1:0]       pvld;
    logic [NUM_SRC*SRC_W-1:0] psrc;
    logic [31:0]              win_word;

    intc_regs #(
        .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .SRC_W(SRC_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .raw_w(raw_w), .irqp_w(irqp_w), .fiqp_w(fiqp_w),
        .win_word(win_word), .mask_o(mask_w), .steer_o(steer_w),
        .wake_sel_o(wake_sel), .pvld_o(pvld), .psrc_o(psrc), .rdata_o(bus_rdata)
    );

    intc_pend #(
        .NUM_SRC(NUM_SRC), .NUM_BANKS(NUM_BANKS)
    ) pend_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_lvl), .mask_i(mask_w),
        .steer_i(steer_w), .wake_sel_i(wake_sel), .raw_w(raw_w),
        .irqp_w(irqp_w), .fiqp_w(fiqp_w), .irq_o(irq_o), .fiq_o(fiq_o),
        .wake_o(wake_o)
    );

    intc_prio #(
        .NUM_SRC(NUM_SRC), .NUM_BANKS(NUM_BANKS), .SRC_W(SRC_W)
    ) prio_i (
        .irqp_w(irqp_w), .pvld_i(pvld), .psrc_i(psrc), .win_word(win_word)
    );
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int NUM_SRC = 96
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_rd,
    input logic [31:0]        bus_rdata,
    input logic [NUM_SRC-1:0] src_lvl,
    input logic               irq_o,
    input logic               fiq_o,
    input logic               wake_o,
    input logic [31:0]        win_word
);
    // R5
    irq_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|src_lvl));
    // R5
    fiq_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(|src_lvl));
    // R8
    winner_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_word[31] |-> irq_o);
    // R8
    winner_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_word[15:0] == 16'h0);
    // R10
    irq_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> wake_o);
    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

bind banked_intc intc_checker #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .src_lvl(src_lvl), .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o),
    .win_word(win_word)
);

// File: tb/banked_intc_tb_top.sv
module banked_intc_tb_top;
    localparam int NSRC = 96;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [8:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NSRC-1:0] src = '0;
    logic            irq_o, fiq_o, wake_o;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    banked_intc #(.NUM_SRC(NSRC), .ADDR_W(9)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_lvl(src), .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic drive(input logic [NSRC-1:0] v);
        @(negedge clk);
        src = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq_o", 32'(irq_o), 0);
        chk("R1 fiq_o", 32'(fiq_o), 0);
        chk("R1 wake_o", 32'(wake_o), 0);
        rd(9'h0A0, d); chk("R1 bank1 mask", d, 0);
        rd(9'h138, d); chk("R1 bank2 steer", d, 0);
        rd(9'h014, d); chk("R1 ctrl", d, 0);
        rd(9'h030, d); chk("R1 slot5", d, 32'h8000_0005);
        rd(9'h018, d); chk("R1 winner", d, 0);
    endtask

    task automatic t_mask_steer();
        logic [31:0] d;
        logic [NSRC-1:0] v;
        v = '0; v[3] = 1'b1; v[40] = 1'b1;
        drive(v);
        rd(9'h010, d); chk("R6 raw bank0", d, 32'h8);
        rd(9'h0AC, d); chk("R6 raw bank1", d, 32'h100);
        chk("R3 masked irq_o", 32'(irq_o), 0);
        chk("R10 wake any raw", 32'(wake_o), 1);
        wr(9'h004, 32'h8);
        chk("R3 irq_o enabled", 32'(irq_o), 1);
        rd(9'h000, d); chk("R3 irq pend bank0", d, 32'h8);
        rd(9'h018, d); chk("R8 winner src3", d, 32'h8003_0000);
        wr(9'h008, 32'h8);
        chk("R4 fiq_o", 32'(fiq_o), 1);
        chk("R4 irq_o off", 32'(irq_o), 0);
        rd(9'h00C, d); chk("R4 fiq pend bank0", d, 32'h8);
        rd(9'h000, d); chk("R4 irq pend cleared", d, 0);
        rd(9'h018, d); chk("R8 fiq never wins", d, 0);
        wr(9'h008, 32'h0);
    endtask

    task automatic t_prio();
        logic [31:0] d;
        wr(9'h0A0, 32'h100);
        rd(9'h018, d); chk("R8 lower slot wins", d, 32'h8003_0000);
        wr(9'h01C, 32'h8000_0028);
        rd(9'h01C, d); chk("R7 slot0 readback", d, 32'h8000_0028);
        rd(9'h018, d); chk("R8 slot0 names 40", d, 32'h8028_0000);
        wr(9'h01C, 32'h0000_0028);
        rd(9'h018, d); chk("R9 invalid slot", d, 32'h8003_0000);
        wr(9'h01C, 32'h8000_0064);
        rd(9'h018, d); chk("R9 out of range slot", d, 32'h8003_0000);
        wr(9'h01C, 32'h8000_0000);
        wr(9'h144, 32'h8000_0011);
        rd(9'h144, d); chk("R7 slot64 readback", d, 32'h8000_0011);
        rd(9'h1C0, d); chk("R7 slot95 reset", d, 32'h8000_005F);
        wr(9'h144, 32'h8000_0040);
    endtask

    task automatic t_wake();
        logic [NSRC-1:0] v;
        wr(9'h004, 32'h0);
        wr(9'h0A0, 32'h0);
        v = '0; v[70] = 1'b1;
        drive(v);
        wr(9'h014, 32'h1);
        chk("R10 masked no wake", 32'(wake_o), 0);
        chk("R3 irq_o masked src70", 32'(irq_o), 0);
        wr(9'h014, 32'h0);
        chk("R10 raw wake", 32'(wake_o), 1);
        wr(9'h014, 32'h1);
        wr(9'h134, 32'h40);
        chk("R10 enabled wake", 32'(wake_o), 1);
        chk("R5 irq_o src70", 32'(irq_o), 1);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        wr(9'h130, 32'h0);
        wr(9'h13C, 32'hFFFF_FFFF);
        wr(9'h140, 32'h0);
        wr(9'h018, 32'h0);
        rd(9'h130, d); chk("R11 irq pend kept", d, 32'h40);
        rd(9'h13C, d); chk("R11 fiq pend kept", d, 0);
        rd(9'h140, d); chk("R11 raw kept", d, 32'h40);
        rd(9'h018, d); chk("R11 winner kept", d, 32'h8046_0000);
        rd(9'h134, d); chk("R2 bank2 mask", d, 32'h40);
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk);
        src = '0;
        chk("R12 irq_o before edge", 32'(irq_o), 1);
        @(negedge clk);
        chk("R12 irq_o drops", 32'(irq_o), 0);
        chk("R12 wake drops", 32'(wake_o), 0);
        rd(9'h018, d); chk("R12 winner cleared", d, 0);
        rd(9'h130, d); chk("R12 pend cleared", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_steer();
        t_prio();
        t_wake();
        t_readonly();
        t_level();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule